// File: doc/BRIEF.md
# Synthesizer Power and Output Routing Controller

This block decides which sections of a three-loop frequency synthesizer are powered: the IF loop, the RF loops and the reference amplifier that both share. The decision combines an active-low hardware power-down pin with software bits that arrive from a serial register block as decoded fields with write strobes. The block also picks which of the two RF loops feeds the single shared RF output, and drives an auxiliary pin from a 2-bit select field.

The RF band is never written directly. Whichever RF divider register was written most recently sets it. Each section enable has a companion one-cycle start pulse that fires when the enable rises, so a downstream tuning sequencer can begin calibration. All inputs are level or strobe signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pwr_route_ctrl`

## Requirements
- R1: While `pwr_pin_n` is 0, `if_en`, `rf_en`, `rf1_en`, `rf2_en` and `ref_en` are 0, whatever the stored bits are.
- R2: While `pwr_pin_n` is 1 and the stored auto bit is 0, `if_en` equals the stored IF bit and `rf_en` equals the stored RF bit (1 = on).
- R3: While `pwr_pin_n` is 1 and the stored auto bit is 1, `if_en` and `rf_en` are both 1.
- R4: `ref_en` is 1 exactly when `if_en` or `rf_en` is 1.
- R5: A cycle with `nrf1_wr` selects RF1 (`rf_band_sel` = 0). A cycle with `nrf2_wr` selects RF2 (`rf_band_sel` = 1). If both strobes are high in the same cycle, RF2 wins. `rf1_en` = `rf_en` with RF1 selected, and `rf2_en` = `rf_en` with RF2 selected. The two are never 1 together.
- R6: With stored aux select 2'b11, `aux_out` follows `lock_fail`. With 2'b01 and with the reserved codes 2'b00 and 2'b10, `aux_out` is 0.
- R7: Strobed writes are stored while `pwr_pin_n` is 0. When the pin returns to 1, the enables reflect those writes.
- R8: After reset the auto, IF and RF bits are 0, RF1 is selected and the aux select is 2'b01, so every output is 0.
- R9: `if_start`, `rf_start` and `ref_start` are each 1 for exactly one cycle, in the first cycle in which the matching enable is 1 after a cycle in which it was 0.
- R10: A strobed write takes effect in the cycle after the strobe. Fields offered without their strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_pin_n | input | 1 | Hardware power-down, active low |
| cfg_wr | input | 1 | Strobe: store `cfg_auto` and `cfg_aux_sel` |
| cfg_auto | input | 1 | Auto bit: forces IF and RF on |
| cfg_aux_sel | input | 2 | Aux select: 01 low, 11 lock-fail, 00/10 reserved |
| pd_wr | input | 1 | Strobe: store `pd_if_on` and `pd_rf_on` |
| pd_if_on | input | 1 | Software IF enable bit |
| pd_rf_on | input | 1 | Software RF enable bit |
| nrf1_wr | input | 1 | RF1 divider write strobe |
| nrf2_wr | input | 1 | RF2 divider write strobe |
| lock_fail | input | 1 | Active-high loop-near-limit flag |
| if_en | output | 1 | IF section enable |
| rf_en | output | 1 | RF section enable |
| ref_en | output | 1 | Reference amplifier enable |
| rf_band_sel | output | 1 | 0 = RF1, 1 = RF2 drives RF output |
| rf1_en | output | 1 | RF1 loop enable |
| rf2_en | output | 1 | RF2 loop enable |
| aux_out | output | 1 | Auxiliary pin |
| if_start | output | 1 | One-cycle pulse on IF enable rise |
| rf_start | output | 1 | One-cycle pulse on RF enable rise |
| ref_start | output | 1 | One-cycle pulse on reference enable rise |

## Verification
The bench writes the software bits while the pin is low and then raises the pin. A design that gated writes with the pin would come back up with stale enables and no start pulses. It drives both divider strobes in the same cycle. A design that let RF1 win, or that turned both RF loops on, would show the wrong band or two active RF enables. It steps the aux select through the reserved codes while toggling `lock_fail`, which exposes any leak of the flag onto the pin. A long stretch of random strobes and pin toggles compares every output each cycle, so start pulses that last two cycles, or that fire again while an enable stays high, are caught.

// File: rtl/pwr_route_pkg.sv
package pwr_route_pkg;
  localparam int AUX_W   = 2;
  localparam int NUM_SEC = 3;
  localparam int SEC_IF  = 0;
  localparam int SEC_RF  = 1;
  localparam int SEC_REF = 2;

  typedef enum logic [AUX_W-1:0] {
    AUX_RSV_A = 2'b00,
    AUX_LOW   = 2'b01,
    AUX_RSV_B = 2'b10,
    AUX_LOCK  = 2'b11
  } aux_sel_e;

  typedef struct packed {
    logic     auto_on;
    logic     if_on;
    logic     rf_on;
    logic     band_rf2;
    aux_sel_e aux_sel;
  } pwr_cfg_t;
endpackage

// File: rtl/pwr_cfg_store.sv
module pwr_cfg_store
  import pwr_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_auto,
  input  logic [AUX_W-1:0] cfg_aux_sel,
  input  logic             pd_wr,
  input  logic             pd_if_on,
  input  logic             pd_rf_on,
  input  logic             nrf1_wr,
  input  logic             nrf2_wr,
  output pwr_cfg_t         cfg_q
);
  // Writes are accepted regardless of the power-down pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.auto_on  <= 1'b0;
      cfg_q.if_on    <= 1'b0;
      cfg_q.rf_on    <= 1'b0;
      cfg_q.band_rf2 <= 1'b0;
      cfg_q.aux_sel  <= AUX_LOW;
    end else begin
      if (cfg_wr) begin
        cfg_q.auto_on <= cfg_auto;
        cfg_q.aux_sel <= aux_sel_e'(cfg_aux_sel);
      end
      if (pd_wr) begin
        cfg_q.if_on <= pd_if_on;
        cfg_q.rf_on <= pd_rf_on;
      end
      // RF2 strobe has priority when both divider writes coincide.
      if (nrf2_wr)      cfg_q.band_rf2 <= 1'b1;
      else if (nrf1_wr) cfg_q.band_rf2 <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_gate.sv
module pwr_gate
  import pwr_route_pkg::*;
#(
  parameter int N_SEC = NUM_SEC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_pin_n,
  input  pwr_cfg_t         cfg_q,
  output logic             if_en,
  output logic             rf_en,
  output logic             ref_en,
  output logic             rf1_en,
  output logic             rf2_en,
  output logic [N_SEC-1:0] sec_start
);
  logic [N_SEC-1:0] sec_en;
  logic [N_SEC-1:0] sec_en_q;

  always_comb begin
    if_en  = pwr_pin_n & (cfg_q.auto_on | cfg_q.if_on);
    rf_en  = pwr_pin_n & (cfg_q.auto_on | cfg_q.rf_on);
    ref_en = if_en | rf_en;
    rf1_en = rf_en & ~cfg_q.band_rf2;
    rf2_en = rf_en &  cfg_q.band_rf2;
    sec_en = '0;
    sec_en[SEC_IF]  = if_en;
    sec_en[SEC_RF]  = rf_en;
    sec_en[SEC_REF] = ref_en;
  end

  for (genvar g = 0; g < N_SEC; g++) begin : g_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_en_q[g] <= 1'b0;
      else        sec_en_q[g] <= sec_en[g];
    end
    assign sec_start[g] = sec_en[g] & ~sec_en_q[g];
  end
endmodule

// File: rtl/aux_route.sv
module aux_route
  import pwr_route_pkg::*;
(
  input  aux_sel_e sel,
  input  logic     lock_fail,
  output logic     aux_out
);
  always_comb begin
    unique case (sel)
      AUX_LOCK: aux_out = lock_fail;
      default:  aux_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwr_route_ctrl.sv
module pwr_route_ctrl
  import pwr_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_pin_n,
  input  logic             cfg_wr,
  input  logic             cfg_auto,
  input  logic [AUX_W-1:0] cfg_aux_sel,
  input  logic             pd_wr,
  input  logic             pd_if_on,
  input  logic             pd_rf_on,
  input  logic             nrf1_wr,
  input  logic             nrf2_wr,
  input  logic             lock_fail,
  output logic             if_en,
  output logic             rf_en,
  output logic             ref_en,
  output logic             rf_band_sel,
  output logic             rf1_en,
  output logic             rf2_en,
  output logic             aux_out,
  output logic             if_start,
  output logic             rf_start,
  output logic             ref_start
);
  pwr_cfg_t           cfg_q;
  logic [NUM_SEC-1:0] sec_start;

  pwr_cfg_store u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_auto(cfg_auto), .cfg_aux_sel(cfg_aux_sel),
    .pd_wr(pd_wr), .pd_if_on(pd_if_on), .pd_rf_on(pd_rf_on),
    .nrf1_wr(nrf1_wr), .nrf2_wr(nrf2_wr),
    .cfg_q(cfg_q)
  );

  pwr_gate #(.N_SEC(NUM_SEC)) u_gate (
    .clk(clk), .rst_n(rst_n), .pwr_pin_n(pwr_pin_n), .cfg_q(cfg_q),
    .if_en(if_en), .rf_en(rf_en), .ref_en(ref_en),
    .rf1_en(rf1_en), .rf2_en(rf2_en), .sec_start(sec_start)
  );

  aux_route u_aux (
    .sel(cfg_q.aux_sel), .lock_fail(lock_fail), .aux_out(aux_out)
  );

  assign rf_band_sel = cfg_q.band_rf2;
  assign if_start    = sec_start[SEC_IF];
  assign rf_start    = sec_start[SEC_RF];
  assign ref_start   = sec_start[SEC_REF];
endmodule

// File: rtl/pwr_route_ctrl_chk.sv
module pwr_route_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_pin_n,
  input logic nrf1_wr,
  input logic nrf2_wr,
  input logic lock_fail,
  input logic if_en,
  input logic rf_en,
  input logic ref_en,
  input logic rf_band_sel,
  input logic rf1_en,
  input logic rf2_en,
  input logic aux_out,
  input logic if_start,
  input logic rf_start
);
  p_pin_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_pin_n |-> (!if_en && !rf_en && !ref_en));
  p_ref_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en == (if_en || rf_en));
  p_one_rf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf1_en && rf2_en));
  p_sel_rf2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nrf2_wr |=> rf_band_sel);
  p_sel_rf1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nrf1_wr && !nrf2_wr) |=> !rf_band_sel);
  p_aux_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_fail |-> !aux_out);
  p_if_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    if_start |=> !if_start);
  p_rf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_start |-> rf_en);
endmodule

bind pwr_route_ctrl pwr_route_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_pin_n(pwr_pin_n),
  .nrf1_wr(nrf1_wr), .nrf2_wr(nrf2_wr), .lock_fail(lock_fail),
  .if_en(if_en), .rf_en(rf_en), .ref_en(ref_en), .rf_band_sel(rf_band_sel),
  .rf1_en(rf1_en), .rf2_en(rf2_en), .aux_out(aux_out),
  .if_start(if_start), .rf_start(rf_start)
);

// File: tb/sim_pwr_route_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_route_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_pin_n = 1'b0, cfg_wr = 1'b0, cfg_auto = 1'b0;
  logic [1:0] cfg_aux_sel = 2'b00;
  logic pd_wr = 1'b0, pd_if_on = 1'b0, pd_rf_on = 1'b0;
  logic nrf1_wr = 1'b0, nrf2_wr = 1'b0, lock_fail = 1'b0;
  logic if_en, rf_en, ref_en, rf_band_sel, rf1_en, rf2_en, aux_out;
  logic if_start, rf_start, ref_start;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_route_ctrl u0 (.*);

  // Behavioural model state
  bit m_auto, m_if, m_rf, m_rf2;
  int m_aux;
  bit l_if, l_rf, l_ref;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_auto <= 0; m_if <= 0; m_rf <= 0; m_rf2 <= 0; m_aux <= 1;
    end else begin
      if (cfg_wr) begin m_auto <= cfg_auto; m_aux <= int'(cfg_aux_sel); end
      if (pd_wr) begin m_if <= pd_if_on; m_rf <= pd_rf_on; end
      if (nrf2_wr) m_rf2 <= 1;
      else if (nrf1_wr) m_rf2 <= 0;
    end
  end

  task automatic chk(input string req, input string nm, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit e_if, e_rf, e_ref, e_aux;
      if (!rst_n) begin
        l_if = 0; l_rf = 0; l_ref = 0;
        chk("R8", "if_en", if_en, 0);
        chk("R8", "rf_en", rf_en, 0);
        chk("R8", "aux_out", aux_out, 0);
      end else begin
        e_if  = pwr_pin_n && (m_auto || m_if);
        e_rf  = pwr_pin_n && (m_auto || m_rf);
        e_ref = e_if || e_rf;
        e_aux = (m_aux == 3) ? lock_fail : 1'b0;
        chk(pwr_pin_n ? (m_auto ? "R3" : "R2") : "R1", "if_en", if_en, e_if);
        chk(pwr_pin_n ? (m_auto ? "R3" : "R2") : "R1", "rf_en", rf_en, e_rf);
        chk("R4", "ref_en", ref_en, e_ref);
        chk("R5", "rf_band_sel", rf_band_sel, m_rf2);
        chk("R5", "rf1_en", rf1_en, e_rf && !m_rf2);
        chk("R5", "rf2_en", rf2_en, e_rf && m_rf2);
        chk("R6", "aux_out", aux_out, e_aux);
        chk("R9", "if_start", if_start, e_if && !l_if);
        chk("R9", "rf_start", rf_start, e_rf && !l_rf);
        chk("R9", "ref_start", ref_start, e_ref && !l_ref);
        l_if = e_if; l_rf = e_rf; l_ref = e_ref;
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cfg_wr = 0; pd_wr = 0; nrf1_wr = 0; nrf2_wr = 0;
    end
  endtask

  task automatic wr_pd(input bit fi, input bit fr);
    pd_wr = 1; pd_if_on = fi; pd_rf_on = fr; pd_if_on = fi;
    step();
  endtask

  task automatic wr_cfg(input bit au, input logic [1:0] sel);
    cfg_wr = 1; cfg_auto = au; cfg_aux_sel = sel;
    step();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;                      // R8 reset values checked each cycle
    step(2);
    pwr_pin_n = 1; step(2);         // R8: still all off
    // R10: field without strobe ignored
    pd_if_on = 1; pd_rf_on = 1; step(3);
    wr_pd(1, 0); step(2);           // R2, R9
    wr_pd(0, 1); step(2);
    wr_pd(1, 1); step(2);
    wr_cfg(1, 2'b01); step(2);      // R3
    wr_pd(0, 0); step(2);           // R3 holds
    pwr_pin_n = 0; step(2);         // R1
    // R7: writes while pin low
    wr_cfg(0, 2'b11);
    wr_pd(1, 1);
    nrf2_wr = 1; step();
    step(2);
    pwr_pin_n = 1; step(3);         // R7, R9
    nrf1_wr = 1; step(2);           // R5
    nrf1_wr = 1; nrf2_wr = 1; step(2); // R5 priority
    // R6: aux codes with lock_fail toggled
    for (int c = 0; c < 4; c++) begin
      wr_cfg(0, 2'(c));
      lock_fail = 1; step(2);
      lock_fail = 0; step(2);
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      pwr_pin_n   = ($urandom % 8) != 0;
      cfg_wr      = ($urandom % 6) == 0;
      cfg_auto    = ($urandom % 4) == 0;
      cfg_aux_sel = 2'($urandom);
      pd_wr       = ($urandom % 3) == 0;
      pd_if_on    = 1'($urandom);
      pd_rf_on    = 1'($urandom);
      nrf1_wr     = ($urandom % 5) == 0;
      nrf2_wr     = ($urandom % 5) == 0;
      lock_fail   = 1'($urandom);
      @(posedge clk); #1;
    end
    cfg_wr = 0; pd_wr = 0; nrf1_wr = 0; nrf2_wr = 0;
    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule